// File: doc/BRIEF.md
# CCD Line Transfer and Readout Sequencer

This block generates the digital gate timing for one line of a two-phase CCD linear imager. It drives the two horizontal clocks, the transfer gate, the photo gate and the output reset gate. It also gives a pixel-valid strobe that tells the converter downstream when to sample. All intervals are counts of the fast system clock, so one netlist serves many line rates.

Each line has two phases. In the first, the horizontal clocks stay parked: the first clock is high and the second is low. Charge then moves from the photodiodes into the shift register through an ordered gate sequence: transfer gate up, photo gate up, photo gate down, transfer gate down. In the second phase the register is shifted out over a fixed number of pixel periods. That number is the active pixel count plus a programmable number of overscan clocks. Each period starts with a reset pulse that ends before the first clock falls.

A line starts with a one-cycle `line_start_i` while the block is idle. The timing fields are captured at that moment and held for the whole line. The transfer then waits for the exposure logic to raise `exp_done_i` and answers it with a one-cycle acknowledge.

Top module: `ccd_line_seq`

## Requirements
- R1: After reset and between lines, h1_o=1, h2_o=0, tg_o=0, pg_o=0, rg_o=1, pix_vld_o=0 and busy_o=0.
- R2: line_start_i is taken only while busy_o=0, and the cfg_* inputs are captured in that cycle. A line_start_i pulse or cfg_* change during a line does not alter that line's timing and does not queue another line.
- R3: tg_o stays low until exp_done_i is seen high after the line start. exp_ack_o is a one-cycle pulse in the cycle after it is seen.
- R4: tg_o rises exactly PARK cycles after exp_ack_o rises.
- R5: pg_o rises exactly LEAD cycles after tg_o rises.
- R6: pg_o stays high for exactly PGW cycles.
- R7: tg_o falls exactly GAP cycles after pg_o falls.
- R8: The first h1_o fall of the line comes exactly HOLD+HALF cycles after tg_o falls.
- R9: h2_o is always the complement of h1_o, and h1_o is high whenever tg_o or pg_o is high.
- R10: Readout has NPIX+OVS periods of 2*HALF cycles each, with h1_o high for the first HALF cycles of each. Successive h1_o falls are 2*HALF apart. line_done_o pulses once, HALF cycles after the last fall, in the same cycle h1_o returns high.
- R11: rg_o is high for the first RSTW cycles of every readout period, then low. It is low whenever h1_o falls.
- R12: pix_vld_o pulses exactly SDLY cycles after each h1_o fall. pix_idx_o counts 0,1,2,... on successive pulses. pix_ovs_o is 1 exactly when pix_idx_o >= NPIX.
- R13: The captured fields are clamped as follows. PARK, LEAD, PGW, GAP and HOLD use 1 when given 0. HALF uses 2 when below 2. RSTW uses 1 when 0 and HALF-1 when at or above HALF. SDLY uses HALF-1 when at or above HALF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| line_start_i | input | 1 | Start a line (taken only when idle) |
| exp_done_i | input | 1 | Exposure finished, transfer may begin |
| exp_ack_o | output | 1 | One-cycle acknowledge of exp_done_i |
| cfg_park_i | input | CW | Cycles from acknowledge to transfer gate rise |
| cfg_lead_i | input | CW | Cycles from transfer gate rise to photo gate rise |
| cfg_pgw_i | input | CW | Photo gate high width |
| cfg_gap_i | input | CW | Cycles from photo gate fall to transfer gate fall |
| cfg_hold_i | input | CW | Parked cycles after transfer gate fall |
| cfg_half_i | input | CW | Half pixel period |
| cfg_rstw_i | input | CW | Reset gate high width per pixel |
| cfg_sdly_i | input | CW | Strobe delay after each first-clock fall |
| cfg_ovs_i | input | OW | Overscan pixel count |
| h1_o | output | 1 | Horizontal clock phase 1 |
| h2_o | output | 1 | Horizontal clock phase 2 |
| tg_o | output | 1 | Transfer gate |
| pg_o | output | 1 | Photo gate |
| rg_o | output | 1 | Output reset gate |
| pix_vld_o | output | 1 | Pixel sample strobe |
| pix_idx_o | output | IW | Index of the strobed pixel |
| pix_ovs_o | output | 1 | Strobed pixel is an overscan clock |
| line_done_o | output | 1 | End-of-line pulse |
| busy_o | output | 1 | Line in progress |

## Verification
The sweep covers every half period from 2 to 5. Each is paired with every reset width from 0 through HALF and with strobe delays of zero, the largest legal value and beyond it. This finds a clamp bound that is off by one: the reset gate would then still be high at the clock fall, or the strobe would slide into the next period. Zero-valued gate intervals check that the transfer phases never collapse to zero width, which would put the photo gate rise in the same cycle as the transfer gate rise. Line starts issued during readout with different settings would expose a design that re-latches mid-line or queues a second line. Overscan counts check the pixel total and the switch of the overscan flag at the NPIX boundary.

// File: rtl/ccd_seq_pkg.sv
package ccd_seq_pkg;

  // Ordering of the gate-interval fields in the captured timing bank.
  localparam int unsigned TI_PARK = 0;
  localparam int unsigned TI_LEAD = 1;
  localparam int unsigned TI_PGW  = 2;
  localparam int unsigned TI_GAP  = 3;
  localparam int unsigned TI_HOLD = 4;
  localparam int unsigned TI_NUM  = 5;

  typedef enum logic [2:0] {
    XS_IDLE,
    XS_ARM,
    XS_PARK,
    XS_LEAD,
    XS_PGON,
    XS_GAP,
    XS_HOLD,
    XS_READ
  } xfer_st_t;

endpackage

// File: rtl/ccd_cfg_shadow.sv
module ccd_cfg_shadow #(
  parameter int unsigned CW = 8,
  parameter int unsigned OW = 4,
  parameter int unsigned NT = 5
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   load,
  input  logic [NT-1:0][CW-1:0]  gate_raw,
  input  logic [CW-1:0]          half_raw,
  input  logic [CW-1:0]          rstw_raw,
  input  logic [CW-1:0]          sdly_raw,
  input  logic [OW-1:0]          ovs_raw,
  output logic [NT-1:0][CW-1:0]  gate_q,
  output logic [CW-1:0]          half_q,
  output logic [CW-1:0]          rstw_q,
  output logic [CW-1:0]          sdly_q,
  output logic [OW-1:0]          ovs_q
);

  localparam logic [CW-1:0] ONE = CW'(1);
  localparam logic [CW-1:0] TWO = CW'(2);

  // Gate intervals: zero is raised to one so no phase vanishes.
  for (genvar gi = 0; gi < NT; gi++) begin : g_gate
    always_ff @(posedge clk) begin
      if (rst) begin
        gate_q[gi] <= ONE;
      end else if (load) begin
        gate_q[gi] <= (gate_raw[gi] == '0) ? ONE : gate_raw[gi];
      end
    end
  end

  logic [CW-1:0] half_c, rstw_c, sdly_c;

  always_comb begin
    half_c = (half_raw < TWO) ? TWO : half_raw;
    if (rstw_raw == '0)          rstw_c = ONE;
    else if (rstw_raw >= half_c) rstw_c = half_c - ONE;
    else                         rstw_c = rstw_raw;
    sdly_c = (sdly_raw >= half_c) ? (half_c - ONE) : sdly_raw;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      half_q <= TWO;
      rstw_q <= ONE;
      sdly_q <= '0;
      ovs_q  <= '0;
    end else if (load) begin
      half_q <= half_c;
      rstw_q <= rstw_c;
      sdly_q <= sdly_c;
      ovs_q  <= ovs_raw;
    end
  end

endmodule

// File: rtl/ccd_xfer_fsm.sv
module ccd_xfer_fsm
  import ccd_seq_pkg::*;
#(
  parameter int unsigned CW = 8
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      line_start,
  input  logic                      exp_done,
  input  logic                      read_done,
  input  logic [TI_NUM-1:0][CW-1:0] tim,
  output logic                      cfg_load,
  output logic                      read_go,
  output logic                      exp_ack,
  output logic                      tg,
  output logic                      pg,
  output logic                      busy
);

  xfer_st_t      st;
  logic [CW-1:0] cnt;
  logic          cnt_end;

  assign cnt_end  = (cnt == '0);
  assign cfg_load = (st == XS_IDLE) && line_start;
  assign read_go  = (st == XS_HOLD) && cnt_end;
  assign busy     = (st != XS_IDLE);

  always_ff @(posedge clk) begin
    if (rst) begin
      st      <= XS_IDLE;
      cnt     <= '0;
      exp_ack <= 1'b0;
      tg      <= 1'b0;
      pg      <= 1'b0;
    end else begin
      exp_ack <= 1'b0;
      if (!cnt_end) cnt <= cnt - 1'b1;
      unique case (st)
        XS_IDLE: if (line_start) st <= XS_ARM;
        XS_ARM: if (exp_done) begin
          st      <= XS_PARK;
          exp_ack <= 1'b1;
          cnt     <= tim[TI_PARK] - 1'b1;
        end
        XS_PARK: if (cnt_end) begin
          st  <= XS_LEAD;
          tg  <= 1'b1;
          cnt <= tim[TI_LEAD] - 1'b1;
        end
        XS_LEAD: if (cnt_end) begin
          st  <= XS_PGON;
          pg  <= 1'b1;
          cnt <= tim[TI_PGW] - 1'b1;
        end
        XS_PGON: if (cnt_end) begin
          st  <= XS_GAP;
          pg  <= 1'b0;
          cnt <= tim[TI_GAP] - 1'b1;
        end
        XS_GAP: if (cnt_end) begin
          st  <= XS_HOLD;
          tg  <= 1'b0;
          cnt <= tim[TI_HOLD] - 1'b1;
        end
        XS_HOLD: if (cnt_end) st <= XS_READ;
        XS_READ: if (read_done) st <= XS_IDLE;
        default: st <= XS_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/ccd_pix_gen.sv
module ccd_pix_gen #(
  parameter int unsigned CW   = 8,
  parameter int unsigned OW   = 4,
  parameter int unsigned NPIX = 1024,
  parameter int unsigned IW   = 11
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          go,
  input  logic [CW-1:0] half,
  input  logic [CW-1:0] rstw,
  input  logic [CW-1:0] sdly,
  input  logic [OW-1:0] ovs,
  output logic          h1,
  output logic          h2,
  output logic          rg,
  output logic          strobe,
  output logic [IW-1:0] idx,
  output logic          ovs_flag,
  output logic          done
);

  localparam int unsigned PW = CW + 1;

  logic          run;
  logic [PW-1:0] ph, nph, per_last, hw, rw, sw;
  logic [IW-1:0] pix, total;
  logic          ph_wrap, line_end;

  always_comb begin
    hw       = {1'b0, half};
    rw       = {1'b0, rstw};
    sw       = hw + {1'b0, sdly};
    per_last = (hw << 1) - 1'b1;
    total    = IW'(NPIX) + IW'(ovs);
    ph_wrap  = (ph == per_last);
    line_end = ph_wrap && (pix == total - 1'b1);
    nph      = ph_wrap ? '0 : ph + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      run      <= 1'b0;
      ph       <= '0;
      pix      <= '0;
      h1       <= 1'b1;
      h2       <= 1'b0;
      rg       <= 1'b1;
      strobe   <= 1'b0;
      idx      <= '0;
      ovs_flag <= 1'b0;
      done     <= 1'b0;
    end else begin
      done   <= 1'b0;
      strobe <= 1'b0;
      if (!run) begin
        if (go) begin
          run <= 1'b1;
          ph  <= '0;
          pix <= '0;
          h1  <= 1'b1;
          h2  <= 1'b0;
          rg  <= 1'b1;
        end
      end else if (line_end) begin
        run  <= 1'b0;
        ph   <= '0;
        h1   <= 1'b1;
        h2   <= 1'b0;
        rg   <= 1'b1;
        done <= 1'b1;
      end else begin
        ph <= nph;
        if (ph_wrap) pix <= pix + 1'b1;
        h1 <= (nph < hw);
        h2 <= (nph >= hw);
        rg <= (nph < rw);
        if (nph == sw) begin
          strobe   <= 1'b1;
          idx      <= pix;
          ovs_flag <= (pix >= IW'(NPIX));
        end
      end
    end
  end

endmodule

// File: rtl/ccd_line_seq.sv
module ccd_line_seq
  import ccd_seq_pkg::*;
#(
  parameter int unsigned CW   = 8,
  parameter int unsigned OW   = 4,
  parameter int unsigned NPIX = 1024,
  localparam int unsigned IW  = $clog2(NPIX + (2 ** OW))
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          line_start_i,
  input  logic          exp_done_i,
  output logic          exp_ack_o,
  input  logic [CW-1:0] cfg_park_i,
  input  logic [CW-1:0] cfg_lead_i,
  input  logic [CW-1:0] cfg_pgw_i,
  input  logic [CW-1:0] cfg_gap_i,
  input  logic [CW-1:0] cfg_hold_i,
  input  logic [CW-1:0] cfg_half_i,
  input  logic [CW-1:0] cfg_rstw_i,
  input  logic [CW-1:0] cfg_sdly_i,
  input  logic [OW-1:0] cfg_ovs_i,
  output logic          h1_o,
  output logic          h2_o,
  output logic          tg_o,
  output logic          pg_o,
  output logic          rg_o,
  output logic          pix_vld_o,
  output logic [IW-1:0] pix_idx_o,
  output logic          pix_ovs_o,
  output logic          line_done_o,
  output logic          busy_o
);

  logic [TI_NUM-1:0][CW-1:0] gate_raw, gate_q;
  logic [CW-1:0]             half_q, rstw_q, sdly_q;
  logic [OW-1:0]             ovs_q;
  logic                      cfg_load, read_go;

  always_comb begin
    gate_raw          = '0;
    gate_raw[TI_PARK] = cfg_park_i;
    gate_raw[TI_LEAD] = cfg_lead_i;
    gate_raw[TI_PGW]  = cfg_pgw_i;
    gate_raw[TI_GAP]  = cfg_gap_i;
    gate_raw[TI_HOLD] = cfg_hold_i;
  end

  ccd_cfg_shadow #(.CW(CW), .OW(OW), .NT(TI_NUM)) u_cfg (
    .clk      (clk),
    .rst      (rst),
    .load     (cfg_load),
    .gate_raw (gate_raw),
    .half_raw (cfg_half_i),
    .rstw_raw (cfg_rstw_i),
    .sdly_raw (cfg_sdly_i),
    .ovs_raw  (cfg_ovs_i),
    .gate_q   (gate_q),
    .half_q   (half_q),
    .rstw_q   (rstw_q),
    .sdly_q   (sdly_q),
    .ovs_q    (ovs_q)
  );

  ccd_xfer_fsm #(.CW(CW)) u_xfer (
    .clk        (clk),
    .rst        (rst),
    .line_start (line_start_i),
    .exp_done   (exp_done_i),
    .read_done  (line_done_o),
    .tim        (gate_q),
    .cfg_load   (cfg_load),
    .read_go    (read_go),
    .exp_ack    (exp_ack_o),
    .tg         (tg_o),
    .pg         (pg_o),
    .busy       (busy_o)
  );

  ccd_pix_gen #(.CW(CW), .OW(OW), .NPIX(NPIX), .IW(IW)) u_pix (
    .clk      (clk),
    .rst      (rst),
    .go       (read_go),
    .half     (half_q),
    .rstw     (rstw_q),
    .sdly     (sdly_q),
    .ovs      (ovs_q),
    .h1       (h1_o),
    .h2       (h2_o),
    .rg       (rg_o),
    .strobe   (pix_vld_o),
    .idx      (pix_idx_o),
    .ovs_flag (pix_ovs_o),
    .done     (line_done_o)
  );

endmodule

// File: rtl/ccd_line_seq_chk.sv
module ccd_line_seq_chk (
  input logic clk,
  input logic rst,
  input logic exp_done_i,
  input logic exp_ack_o,
  input logic h1_o,
  input logic h2_o,
  input logic tg_o,
  input logic pg_o,
  input logic rg_o,
  input logic pix_vld_o,
  input logic busy_o
);

  // R3
  ack_after_done_chk: assert property (@(posedge clk) disable iff (rst)
    exp_ack_o |-> $past(exp_done_i) && !tg_o);

  // R9
  parked_during_xfer_chk: assert property (@(posedge clk) disable iff (rst)
    (tg_o || pg_o) |-> (h1_o && !h2_o));

  // R9
  clocks_opposed_chk: assert property (@(posedge clk) disable iff (rst)
    h1_o != h2_o);

  // R5
  pg_after_tg_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(pg_o) |-> $past(tg_o));

  // R6
  pg_inside_tg_chk: assert property (@(posedge clk) disable iff (rst)
    pg_o |-> tg_o);

  // R7
  tg_falls_after_pg_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(tg_o) |-> !$past(pg_o));

  // R11
  reset_low_at_h1_fall_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(h1_o) |-> (!rg_o && !$past(rg_o)));

  // R12
  strobe_in_line_chk: assert property (@(posedge clk) disable iff (rst)
    pix_vld_o |-> (busy_o && !h1_o));

endmodule

bind ccd_line_seq ccd_line_seq_chk u_chk (
  .clk        (clk),
  .rst        (rst),
  .exp_done_i (exp_done_i),
  .exp_ack_o  (exp_ack_o),
  .h1_o       (h1_o),
  .h2_o       (h2_o),
  .tg_o       (tg_o),
  .pg_o       (pg_o),
  .rg_o       (rg_o),
  .pix_vld_o  (pix_vld_o),
  .busy_o     (busy_o)
);

// File: tb/sim_ccd_line_seq.sv
`timescale 1ns/1ps
module sim_ccd_line_seq;

  localparam int CW   = 8;
  localparam int OW   = 4;
  localparam int NPIX = 6;
  localparam int IW   = $clog2(NPIX + (2 ** OW));

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic line_start_i = 1'b0, exp_done_i = 1'b0;
  logic [CW-1:0] cfg_park_i = '0, cfg_lead_i = '0, cfg_pgw_i = '0, cfg_gap_i = '0;
  logic [CW-1:0] cfg_hold_i = '0, cfg_half_i = '0, cfg_rstw_i = '0, cfg_sdly_i = '0;
  logic [OW-1:0] cfg_ovs_i = '0;
  logic exp_ack_o, h1_o, h2_o, tg_o, pg_o, rg_o, pix_vld_o, pix_ovs_o, line_done_o, busy_o;
  logic [IW-1:0] pix_idx_o;

  always #5 clk = ~clk;

  ccd_line_seq #(.CW(CW), .OW(OW), .NPIX(NPIX)) u0 (.*);

  int n_chk = 0, n_err = 0;
  bit finished = 1'b0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // expected (clamped) values for the current line
  int epark, elead, epgw, egap, ehold, eh, er, es, etot;
  // monitor state
  int cyc = 0;
  int t_ack, t_tgr, t_pgr, t_pgf, t_tgf, t_pst, t_lastf, n_f, n_s, n_done;
  bit mon_on = 1'b0;
  logic p_h1 = 1'b1, p_tg = 1'b0, p_pg = 1'b0, p_rg = 1'b1;

  function automatic int min1(input int v); return (v < 1) ? 1 : v; endfunction

  always @(negedge clk) begin
    cyc++;
    if (mon_on) begin
      chk(h2_o == !h1_o, "R9 h2 complement", h2_o, !h1_o);
      if (tg_o || pg_o) chk(h1_o == 1'b1, "R9 h1 parked", h1_o, 1);
      if (exp_ack_o) t_ack = cyc;
      if (tg_o && !p_tg) begin t_tgr = cyc; chk(cyc - t_ack == epark, "R4 park", cyc - t_ack, epark); end
      if (pg_o && !p_pg) begin t_pgr = cyc; chk(cyc - t_tgr == elead, "R5 lead", cyc - t_tgr, elead); end
      if (!pg_o && p_pg) begin t_pgf = cyc; chk(cyc - t_pgr == epgw, "R6 pg width", cyc - t_pgr, epgw); end
      if (!tg_o && p_tg) begin
        t_tgf = cyc; t_pst = cyc + ehold;
        chk(cyc - t_pgf == egap, "R7 gap", cyc - t_pgf, egap);
      end
      if (h1_o && !p_h1) t_pst = cyc;
      if (!rg_o && p_rg) chk(cyc - t_pst == er, "R11 reset width", cyc - t_pst, er);
      if (!h1_o && p_h1) begin
        chk(rg_o == 1'b0, "R11 rg low at h1 fall", rg_o, 0);
        if (n_f == 0) chk(cyc - t_tgf == ehold + eh, "R8 first fall", cyc - t_tgf, ehold + eh);
        else          chk(cyc - t_lastf == 2 * eh, "R10 period", cyc - t_lastf, 2 * eh);
        n_f++; t_lastf = cyc;
      end
      if (pix_vld_o) begin
        chk(cyc - t_lastf == es, "R12 strobe delay", cyc - t_lastf, es);
        chk(int'(pix_idx_o) == n_s, "R12 index", pix_idx_o, n_s);
        chk(pix_ovs_o == (n_s >= NPIX), "R12 overscan flag", pix_ovs_o, n_s >= NPIX);
        n_s++;
      end
      if (line_done_o) begin
        n_done++;
        chk(n_f == etot, "R10 pixel count", n_f, etot);
        chk(n_s == etot, "R12 strobe count", n_s, etot);
        chk(h1_o && !p_h1, "R10 h1 returns high", h1_o, 1);
        chk(cyc - t_lastf == eh, "R10 done timing", cyc - t_lastf, eh);
      end
    end
    p_h1 = h1_o; p_tg = tg_o; p_pg = pg_o; p_rg = rg_o;
  end

  task automatic run_line(input int park, lead, pgw, gap, hold, half, rstw, sdly, ovs, wait_exp);
    int e0;
    bit clamped;
    @(negedge clk); #1;
    epark = min1(park); elead = min1(lead); epgw = min1(pgw); egap = min1(gap); ehold = min1(hold);
    eh = (half < 2) ? 2 : half;
    er = (rstw < 1) ? 1 : ((rstw >= eh) ? eh - 1 : rstw);
    es = (sdly >= eh) ? eh - 1 : sdly;
    etot = NPIX + ovs;
    clamped = (park == 0) || (lead == 0) || (pgw == 0) || (gap == 0) || (hold == 0) ||
              (half < 2) || (rstw == 0) || (rstw >= eh) || (sdly >= eh);
    e0 = n_err;
    t_ack = -1000; t_tgr = -1000; t_pgr = -1000; t_pgf = -1000; t_tgf = -1000;
    t_pst = -1000; t_lastf = -1000; n_f = 0; n_s = 0; n_done = 0; mon_on = 1'b1;
    cfg_park_i = CW'(park); cfg_lead_i = CW'(lead); cfg_pgw_i = CW'(pgw); cfg_gap_i = CW'(gap);
    cfg_hold_i = CW'(hold); cfg_half_i = CW'(half); cfg_rstw_i = CW'(rstw); cfg_sdly_i = CW'(sdly);
    cfg_ovs_i = OW'(ovs);
    line_start_i = 1'b1;
    @(negedge clk); #1;
    line_start_i = 1'b0;
    // R2: scramble the inputs right after capture
    cfg_half_i = CW'(half + 3); cfg_pgw_i = CW'(pgw + 4); cfg_ovs_i = OW'(ovs + 1);
    repeat (wait_exp) @(negedge clk);
    #1;
    chk(t_tgr < 0 && t_ack < 0, "R3 no transfer before exposure", t_tgr, -1000);
    exp_done_i = 1'b1;
    while (!exp_ack_o) @(negedge clk);
    #1;
    exp_done_i = 1'b0;
    @(negedge clk); #1;
    chk(exp_ack_o == 1'b0, "R3 ack one cycle", exp_ack_o, 0);
    while (n_s == 0) @(negedge clk);
    #1;
    line_start_i = 1'b1;  // R2: ignored mid-line
    @(negedge clk); #1;
    line_start_i = 1'b0;
    while (n_done == 0) @(negedge clk);
    repeat (6) @(negedge clk);
    #1;
    chk(busy_o == 1'b0 && tg_o == 1'b0, "R2 no queued line", busy_o, 0);
    chk(h1_o && !h2_o && !tg_o && !pg_o && rg_o && !pix_vld_o, "R1 idle levels", h1_o, 1);
    chk(n_done == 1, "R10 single done", n_done, 1);
    if (clamped) chk(n_err == e0, "R13 clamped timing", n_err - e0, 0);
    mon_on = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    #1;
    chk(h1_o && !h2_o && !tg_o && !pg_o && rg_o && !pix_vld_o && !busy_o && !exp_ack_o,
        "R1 reset state", {h1_o, h2_o, tg_o, pg_o, rg_o}, 5'b10001);
    rst = 1'b0;
    @(negedge clk); #1;
    chk(!busy_o && !tg_o, "R1 idle after reset", busy_o, 0);
    run_line(1, 1, 1, 1, 1, 2, 1, 0, 0, 0);
    run_line(0, 0, 0, 0, 0, 0, 0, 0, 0, 3);
    run_line(3, 2, 18, 1, 3, 5, 9, 9, 3, 20);
    run_line(2, 4, 20, 2, 5, 3, 1, 1, 15, 1);
    for (int h = 2; h <= 5; h++)
      for (int r = 0; r <= h; r++)
        for (int s = 0; s < 3; s++)
          run_line(r, h - 1, 2 + s, s, r + 1, h,
                   r, (s == 0) ? 0 : ((s == 1) ? h - 1 : h + 2), (h + r + s) % 4, s);
    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_err++;
      $display("FAIL watchdog actual=%0d expected=%0d", 150000, 0);
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

endmodule